// File: doc/BRIEF.md
# Photon Arrival Time-Tagger

This block stamps every rising edge seen on an asynchronous photodetector line with the time since the most recent sequence-start strobe. A free-running timestamp counter runs in the block clock domain. Its resolution is one clock period, so a 100 MHz clock gives 10 ns bins. The counter restarts from zero on each start strobe.

The detector line passes through a two-flop synchronizer and then a rising-edge detector, which produces one tag event per pulse. Each event pushes the current timestamp into an on-chip buffer. The start strobe does not touch the buffer, so tags from many repeated runs pile up until the host drains them in one batch.

The read side is a valid/ready stream. `rd_valid` is high while the buffer holds at least one tag, and `rd_data` shows the oldest tag. A tag is consumed on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, the presented tag and `rd_valid` hold unchanged, so the consumer can stall for any number of cycles.

When the buffer is full, new tags are discarded and a sticky overflow flag is raised. A clear command empties the buffer and drops the flag.

Top module: `photon_tagger`

## Requirements
- R1: After reset, `tag_count` is 0, `rd_valid` is 0 and `overflow` is 0.
- R2: Each rising edge of `det_in` produces exactly one tag, however long the line then stays high; a pulse high for only one clock cycle still produces one tag.
- R3: When `seq_start` is sampled high at clock edge 0, the timestamp restarts from zero. If `det_in` first goes high between edges k and k+1 after that edge, the stored tag equals k+2: two synchronizer stages, then a write on the third edge.
- R4: The timestamp saturates at its all-ones value (65535 with the default 16-bit width) and does not wrap until the next `seq_start`.
- R5: `seq_start` leaves buffered tags untouched, so tags from several runs accumulate in arrival order.
- R6: Tags are read out oldest first. Each handshake (`rd_valid` and `rd_ready` high at an edge) removes one tag and lowers `tag_count` by one. While `rd_ready` is low, `rd_valid` and `rd_data` stay stable.
- R7: With DEPTH tags stored, a further tag is dropped, the stored tags are preserved, and `overflow` goes high. `overflow` then stays high, even after the buffer is drained, until a clear.
- R8: `clr` empties the buffer and lowers `overflow` at the next edge. If a tag write falls on the same edge, the clear wins and the tag is discarded.
- R9: A tag write and a read handshake on the same edge, with the buffer neither empty nor full, leave `tag_count` unchanged, and the new tag queues behind the remaining ones.
- R10: Pulses arriving every second clock cycle (the maximum rate the edge detector can resolve) are all tagged, two counts apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one period is one timestamp bin |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_in | input | 1 | Asynchronous photodetector pulse line |
| seq_start | input | 1 | One-cycle strobe marking the start of a sequence run |
| clr | input | 1 | Empties the tag buffer and clears the overflow flag |
| rd_valid | output | 1 | A tag is available on `rd_data` |
| rd_ready | input | 1 | Consumer accepts the presented tag |
| rd_data | output | TS_W (16) | Oldest buffered timestamp |
| tag_count | output | $clog2(DEPTH+1) (5) | Number of tags pending in the buffer |
| overflow | output | 1 | Sticky: a tag was lost because the buffer was full |

## Verification
The bench aims at the off-by-one places in the tag path. A synchronizer one stage too short or long, or a write that takes the updated timestamp, shifts every tag by a count. A restart that also resets the write pointer loses the earlier runs' tags. A timestamp counter that wraps returns small values after a long delay. On the buffer side, the bench fills to exactly DEPTH and one beyond, where a wrong full test overwrites the oldest tag or fails to set the flag. It also holds a tag under back-pressure, where a mis-gated read pointer would skip an entry. Finally, it lines up a write with a read and a write with a clear on the same edge, where wrong priority gives a miscounted or surviving tag.

// File: rtl/ptag_pkg.sv
package ptag_pkg;
  // Default widths shared by the block and its checker.
  localparam int unsigned PTAG_TS_W        = 16;
  localparam int unsigned PTAG_DEPTH       = 16;
  localparam int unsigned PTAG_SYNC_STAGES = 2;

  // Width of an occupancy counter able to hold 0..depth.
  function automatic int unsigned occ_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/ptag_edge_sync.sv
module ptag_edge_sync #(
  parameter int unsigned STAGES = ptag_pkg::PTAG_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_evt
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise_evt = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/ptag_timebase.sv
module ptag_timebase #(
  parameter int unsigned TS_W = ptag_pkg::PTAG_TS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  output logic [TS_W-1:0] ts
);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ts <= '0;
    else if (restart)       ts <= '0;
    else if (ts != TS_MAX)  ts <= ts + 1'b1;
  end
endmodule

// File: rtl/ptag_buffer.sv
module ptag_buffer #(
  parameter int unsigned DW    = ptag_pkg::PTAG_TS_W,
  parameter int unsigned DEPTH = ptag_pkg::PTAG_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [ptag_pkg::occ_width(DEPTH)-1:0] count,
  output logic          overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = ptag_pkg::occ_width(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, do_wr, do_rd;

  assign full     = (count == FULL);
  assign rd_valid = (count != '0);
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_valid && rd_ready;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr && !clr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; overflow <= 1'b0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; count <= '0; overflow <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/photon_tagger.sv
module photon_tagger #(
  parameter int unsigned TS_W  = ptag_pkg::PTAG_TS_W,
  parameter int unsigned DEPTH = ptag_pkg::PTAG_DEPTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            det_in,
  input  logic            seq_start,
  input  logic            clr,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [TS_W-1:0] rd_data,
  output logic [ptag_pkg::occ_width(DEPTH)-1:0] tag_count,
  output logic            overflow
);
  logic            tag_evt;
  logic [TS_W-1:0] ts_now;

  ptag_edge_sync #(.STAGES(ptag_pkg::PTAG_SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(det_in), .rise_evt(tag_evt)
  );

  ptag_timebase #(.TS_W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .restart(seq_start), .ts(ts_now)
  );

  ptag_buffer #(.DW(TS_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(tag_evt), .wr_data(ts_now),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .count(tag_count), .overflow(overflow)
  );
endmodule

// File: rtl/photon_tagger_checker.sv
module photon_tagger_checker #(
  parameter int unsigned TS_W  = ptag_pkg::PTAG_TS_W,
  parameter int unsigned DEPTH = ptag_pkg::PTAG_DEPTH
) (
  input logic            clk,
  input logic            rst_n,
  input logic            seq_start,
  input logic            clr,
  input logic            tag_evt,
  input logic [TS_W-1:0] ts_now,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [TS_W-1:0] rd_data,
  input logic [ptag_pkg::occ_width(DEPTH)-1:0] tag_count,
  input logic            overflow
);
  localparam int unsigned CW = ptag_pkg::occ_width(DEPTH);
  localparam logic [CW-1:0]   FULL   = CW'(DEPTH);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  p_single_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tag_evt |=> !tag_evt);

  p_ts_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> ts_now == '0);

  p_ts_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_now == TS_MAX && !seq_start) |=> ts_now == TS_MAX);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !clr) |=> (rd_valid && $stable(rd_data)));

  p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !tag_evt && !clr) |=> tag_count == $past(tag_count) - 1'b1);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);

  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_count <= FULL);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tag_count == '0 && !overflow));

  p_simul_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_evt && rd_valid && rd_ready && !clr && tag_count != FULL) |=> $stable(tag_count));
endmodule

bind photon_tagger photon_tagger_checker #(.TS_W(TS_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .clr(clr),
  .tag_evt(tag_evt), .ts_now(ts_now), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .tag_count(tag_count), .overflow(overflow)
);

// File: tb/tb_photon_tagger.sv
`timescale 1ns/1ps
module tb_photon_tagger;
  localparam int TS_W  = 16;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TSMAX = (1 << TS_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic det_in = 1'b0, seq_start = 1'b0, clr = 1'b0, rd_ready = 1'b0;
  logic rd_valid, overflow;
  logic [TS_W-1:0] rd_data;
  logic [CW-1:0]   tag_count;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  photon_tagger #(.TS_W(TS_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .det_in(det_in), .seq_start(seq_start), .clr(clr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .tag_count(tag_count), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic start_seq();
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    cyc = 0;
  endtask

  function automatic int expect_tag(input int c);
    return (c + 2 > TSMAX) ? TSMAX : c + 2;
  endfunction

  // Two-cycle pulse slot: high one cycle, low one cycle.
  task automatic pulse();
    det_in = 1'b1;
    exp_q.push_back(expect_tag(cyc));
    tick();
    det_in = 1'b0;
    tick();
  endtask

  task automatic settle();
    repeat (4) tick();
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      int e = exp_q.pop_front();
      check(rd_valid == 1'b1, req, rd_valid, 1);
      check(rd_data == e[TS_W-1:0], req, rd_data, e);
      rd_ready = 1'b1;
      tick();
      rd_ready = 1'b0;
    end
    check(tag_count == 0, req, tag_count, 0);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    exp_q.delete();
  endtask

  task automatic t_reset();
    check(tag_count == 0, "R1 count", tag_count, 0);
    check(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
  endtask

  task automatic t_timing_and_rate();
    // R3 tag values, R10 back-to-back pulses every second cycle
    start_seq();
    repeat (8) pulse();
    settle();
    check(tag_count == 8, "R10 count", tag_count, 8);
    drain("R3/R10 tag value");
  endtask

  task automatic t_long_high();
    // R2: long high level -> single tag; short 1-cycle pulse -> single tag
    start_seq();
    repeat (3) tick();
    det_in = 1'b1;
    exp_q.push_back(expect_tag(cyc));
    repeat (7) tick();
    det_in = 1'b0;
    repeat (5) tick();
    pulse();
    settle();
    check(tag_count == 2, "R2 one tag per edge", tag_count, 2);
    drain("R2 tag value");
  endtask

  task automatic t_multi_run();
    // R5: several runs accumulate, order preserved
    for (int r = 0; r < 3; r++) begin
      start_seq();
      repeat (r * 5) tick();
      pulse();
      pulse();
      settle();
    end
    check(tag_count == 6, "R5 accumulated count", tag_count, 6);
    drain("R5 run order");
  endtask

  task automatic t_backpressure();
    // R6: valid/data hold while ready is low
    start_seq();
    pulse();
    repeat (3) tick();
    pulse();
    settle();
    repeat (6) begin
      tick();
      check(rd_valid == 1'b1, "R6 hold valid", rd_valid, 1);
      check(rd_data == exp_q[0][TS_W-1:0], "R6 hold data", rd_data, exp_q[0]);
    end
    check(tag_count == 2, "R6 count under stall", tag_count, 2);
    rd_ready = 1'b1;
    tick();
    rd_ready = 1'b0;
    check(tag_count == 1, "R6 decrement", tag_count, 1);
    void'(exp_q.pop_front());
    drain("R6 order");
  endtask

  task automatic t_overflow();
    // R7: fill beyond DEPTH
    do_clear();
    start_seq();
    repeat (DEPTH + 2) pulse();
    settle();
    while (exp_q.size() > DEPTH) void'(exp_q.pop_back());
    check(tag_count == DEPTH, "R7 full count", tag_count, DEPTH);
    check(overflow == 1'b1, "R7 overflow set", overflow, 1);
    drain("R7 preserved tags");
    check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
    do_clear();
    check(overflow == 1'b0, "R8 clear overflow", overflow, 0);
  endtask

  task automatic t_clear_priority();
    // R8: clear wins over a same-edge write, and empties the buffer
    start_seq();
    pulse();
    settle();
    det_in = 1'b1;
    tick();
    det_in = 1'b0;
    tick();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    exp_q.delete();
    repeat (3) tick();
    check(tag_count == 0, "R8 cleared count", tag_count, 0);
    check(rd_valid == 1'b0, "R8 cleared valid", rd_valid, 0);
  endtask

  task automatic t_simultaneous();
    // R9: write and read on the same edge
    start_seq();
    pulse();
    settle();
    det_in = 1'b1;
    exp_q.push_back(expect_tag(cyc));
    tick();
    det_in = 1'b0;
    tick();
    rd_ready = 1'b1;
    tick();
    rd_ready = 1'b0;
    void'(exp_q.pop_front());
    check(tag_count == 1, "R9 count unchanged", tag_count, 1);
    drain("R9 new tag");
  endtask

  task automatic t_saturate();
    // R4: timestamp saturates
    start_seq();
    repeat (TSMAX + 500) tick();
    pulse();
    settle();
    drain("R4 saturated tag");
    start_seq();
    pulse();
    settle();
    drain("R4 restart after saturation");
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_timing_and_rate();
    t_long_high();
    t_multi_run();
    t_backpressure();
    t_overflow();
    t_clear_priority();
    t_simultaneous();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule